// File: doc/BRIEF.md
# Pin Function Multiplexer Register Bank

This block holds the configuration registers for a bank of pins and does the per-pin multiplexing that goes with them. Each pin belongs either to the general-purpose I/O logic or to one of four internal peripheral functions, A to D. When a pin belongs to the GPIO logic, the block drives it from its own output-data and output-enable registers. When a peripheral owns the pin, the drive value and drive enable come from that function's input buses. An open-drain mode can be set per pin, and every pin has pull-up and pull-down enables that can never be on together.

Software reaches the bank through one write port and one read port. A write names a register and carries two masks, one of bits to set and one of bits to clear, so one write can turn bits on and off in the same register. The two function-select registers work differently: they load the set mask as a plain value. The read port returns register contents and the synchronised pad levels.

Top module: `pmux_bank`

## Requirements
- R1: While reset is asserted and after it is released, every pin is owned by GPIO (read address 0 gives all ones), output data and output enable are zero, the pull-up is on for all pins, the pull-down is off, open drain is off and both select registers are zero.
- R2: A write to address 0 (ownership) hands each pin whose set bit is 1 to GPIO and each pin whose clear bit is 1 to a peripheral. Reading address 0 returns 1 for GPIO-owned pins. Ownership changes on no other write.
- R3: Select registers at address 6 (low bit) and 7 (high bit) load the set mask on a write and change at no other time. For a peripheral-owned pin, the code {high,low} picks 00 = A, 01 = B, 10 = C, 11 = D, and the pin takes its drive value and drive enable from that function's buses.
- R4: Output data (address 1) and output enable (address 2) are set/clear registers. Mask bits that are zero leave their bits alone. On a GPIO-owned pin without open drain, pad_out and pad_oe equal these register bits.
- R5: If the set and clear masks of one write both carry a 1 for the same bit, that bit ends up cleared.
- R6: Pull-up (address 3) and pull-down (address 4) are set/clear registers. Setting a pull-down bit clears that pin's pull-up bit, and setting a pull-up bit clears its pull-down bit. pad_pu and pad_pd are never both 1 on the same pin.
- R7: With open drain set (address 5), a pin never drives high. pad_out is 0 and pad_oe is 1 only when the selected source enables its output with a value of 0. This applies to GPIO-owned and peripheral-owned pins alike.
- R8: Reading address 8 returns pad_in as it was SYNC_STAGES clock edges earlier, whatever each pin's ownership. Unmapped read addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Register written |
| wr_set | input | NPINS | Bits to set, or the value for select registers |
| wr_clr | input | NPINS | Bits to clear |
| rd_addr | input | 4 | Register read |
| rd_data | output | NPINS | Read data, combinational from rd_addr |
| pad_in | input | NPINS | Pad levels |
| fn_a_val | input | NPINS | Function A drive values |
| fn_a_oe | input | NPINS | Function A drive enables |
| fn_b_val | input | NPINS | Function B drive values |
| fn_b_oe | input | NPINS | Function B drive enables |
| fn_c_val | input | NPINS | Function C drive values |
| fn_c_oe | input | NPINS | Function C drive enables |
| fn_d_val | input | NPINS | Function D drive values |
| fn_d_oe | input | NPINS | Function D drive enables |
| pad_out | output | NPINS | Pad drive value |
| pad_oe | output | NPINS | Pad drive enable |
| pad_pu | output | NPINS | Pull-up enable |
| pad_pd | output | NPINS | Pull-down enable |

## Verification
The assertions watch four things on every cycle. Pull-up and pull-down are never on together. A pin in open-drain mode never drives high. A colliding set and clear always leaves the bit cleared. Ownership and select registers move only on writes to their own addresses. Only the bench scenarios can show the reset values, the choice among the four functions for each select code, GPIO output following its registers, and the pad-level latency, because each of these needs a known stimulus and an expected value.

// File: rtl/pmux_pkg.sv
package pmux_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_OWN = 4'd0,
    REG_OUT = 4'd1,
    REG_OE  = 4'd2,
    REG_PU  = 4'd3,
    REG_PD  = 4'd4,
    REG_OD  = 4'd5,
    REG_SLO = 4'd6,
    REG_SHI = 4'd7,
    REG_PAD = 4'd8
  } pmux_reg_e;

  typedef enum logic [1:0] {
    FN_A = 2'b00,
    FN_B = 2'b01,
    FN_C = 2'b10,
    FN_D = 2'b11
  } pmux_fn_e;
endpackage

// File: rtl/pmux_sync.sv
module pmux_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st_q, st_d;

  always_comb begin
    st_d[0] = d;
    for (int k = 1; k < STAGES; k++) st_d[k] = st_q[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= {STAGES{RST_VAL}};
    else        st_q <= st_d;
  end

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/pmux_setclr_reg.sv
module pmux_setclr_reg #(
  parameter int W = 32,
  parameter logic [W-1:0] RST_VAL = '0,
  parameter bit PLAIN = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    if (PLAIN) q_d = set;
    else       q_d = (q | set) & ~clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST_VAL;
    else if (we) q <= q_d;
  end

  generate
    if (!PLAIN) begin : g_chk
      AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (|(set & clr))) |=> ((q & $past(set & clr)) == '0)) // R5
        else $error("clear did not win over set");
    end
  endgenerate
endmodule

// File: rtl/pmux_pin_mux.sv
module pmux_pin_mux
  import pmux_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic [NPINS-1:0] own,
  input  logic [NPINS-1:0] gp_val,
  input  logic [NPINS-1:0] gp_oe,
  input  logic [NPINS-1:0] od,
  input  logic [NPINS-1:0] sel_lo,
  input  logic [NPINS-1:0] sel_hi,
  input  logic [NPINS-1:0] fa_val,
  input  logic [NPINS-1:0] fa_oe,
  input  logic [NPINS-1:0] fb_val,
  input  logic [NPINS-1:0] fb_oe,
  input  logic [NPINS-1:0] fc_val,
  input  logic [NPINS-1:0] fc_oe,
  input  logic [NPINS-1:0] fd_val,
  input  logic [NPINS-1:0] fd_oe,
  output logic [NPINS-1:0] drv_val,
  output logic [NPINS-1:0] drv_oe
);
  generate
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
      logic per_val, per_oe, src_val, src_oe;

      always_comb begin
        unique case (pmux_fn_e'({sel_hi[i], sel_lo[i]}))
          FN_A:    begin per_val = fa_val[i]; per_oe = fa_oe[i]; end
          FN_B:    begin per_val = fb_val[i]; per_oe = fb_oe[i]; end
          FN_C:    begin per_val = fc_val[i]; per_oe = fc_oe[i]; end
          default: begin per_val = fd_val[i]; per_oe = fd_oe[i]; end
        endcase
      end

      assign src_val = own[i] ? gp_val[i] : per_val;
      assign src_oe  = own[i] ? gp_oe[i]  : per_oe;

      assign drv_val[i] = od[i] ? 1'b0 : src_val;
      assign drv_oe[i]  = od[i] ? (src_oe & ~src_val) : src_oe;
    end
  endgenerate
endmodule

// File: rtl/pmux_bank.sv
module pmux_bank
  import pmux_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [NPINS-1:0]     wr_set,
  input  logic [NPINS-1:0]     wr_clr,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [NPINS-1:0]     rd_data,
  input  logic [NPINS-1:0]     pad_in,
  input  logic [NPINS-1:0]     fn_a_val,
  input  logic [NPINS-1:0]     fn_a_oe,
  input  logic [NPINS-1:0]     fn_b_val,
  input  logic [NPINS-1:0]     fn_b_oe,
  input  logic [NPINS-1:0]     fn_c_val,
  input  logic [NPINS-1:0]     fn_c_oe,
  input  logic [NPINS-1:0]     fn_d_val,
  input  logic [NPINS-1:0]     fn_d_oe,
  output logic [NPINS-1:0]     pad_out,
  output logic [NPINS-1:0]     pad_oe,
  output logic [NPINS-1:0]     pad_pu,
  output logic [NPINS-1:0]     pad_pd
);
  localparam logic [NPINS-1:0] ALL1 = {NPINS{1'b1}};
  localparam logic [NPINS-1:0] ALL0 = '0;

  logic rst_q;
  logic own_we, out_we, oe_we, od_we, slo_we, shi_we, pu_we, pd_we;
  logic [NPINS-1:0] pu_set, pu_clr, pd_set, pd_clr;
  logic [NPINS-1:0] own_q, out_q, oe_q, od_q, slo_q, shi_q, pu_q, pd_q, pad_q;

  pmux_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_rst (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_q));

  pmux_sync #(.W(NPINS), .STAGES(SYNC_STAGES), .RST_VAL(ALL0)) u_pad (
    .clk(clk), .rst_n(rst_q), .d(pad_in), .q(pad_q));

  always_comb begin
    own_we = wr_en && (wr_addr == REG_OWN);
    out_we = wr_en && (wr_addr == REG_OUT);
    oe_we  = wr_en && (wr_addr == REG_OE);
    od_we  = wr_en && (wr_addr == REG_OD);
    slo_we = wr_en && (wr_addr == REG_SLO);
    shi_we = wr_en && (wr_addr == REG_SHI);
    pu_we  = wr_en && ((wr_addr == REG_PU) || (wr_addr == REG_PD));
    pd_we  = pu_we;
    if (wr_addr == REG_PU) begin
      pu_set = wr_set;  pu_clr = wr_clr;
      pd_set = ALL0;    pd_clr = wr_set;
    end else begin
      pu_set = ALL0;    pu_clr = wr_set;
      pd_set = wr_set;  pd_clr = wr_clr;
    end
  end

  pmux_setclr_reg #(.W(NPINS), .RST_VAL(ALL1)) u_own (
    .clk(clk), .rst_n(rst_q), .we(own_we), .set(wr_set), .clr(wr_clr), .q(own_q));
  pmux_setclr_reg #(.W(NPINS), .RST_VAL(ALL0)) u_out (
    .clk(clk), .rst_n(rst_q), .we(out_we), .set(wr_set), .clr(wr_clr), .q(out_q));
  pmux_setclr_reg #(.W(NPINS), .RST_VAL(ALL0)) u_oe (
    .clk(clk), .rst_n(rst_q), .we(oe_we), .set(wr_set), .clr(wr_clr), .q(oe_q));
  pmux_setclr_reg #(.W(NPINS), .RST_VAL(ALL0)) u_od (
    .clk(clk), .rst_n(rst_q), .we(od_we), .set(wr_set), .clr(wr_clr), .q(od_q));
  pmux_setclr_reg #(.W(NPINS), .RST_VAL(ALL1)) u_pu (
    .clk(clk), .rst_n(rst_q), .we(pu_we), .set(pu_set), .clr(pu_clr), .q(pu_q));
  pmux_setclr_reg #(.W(NPINS), .RST_VAL(ALL0)) u_pd (
    .clk(clk), .rst_n(rst_q), .we(pd_we), .set(pd_set), .clr(pd_clr), .q(pd_q));
  pmux_setclr_reg #(.W(NPINS), .RST_VAL(ALL0), .PLAIN(1'b1)) u_slo (
    .clk(clk), .rst_n(rst_q), .we(slo_we), .set(wr_set), .clr(wr_clr), .q(slo_q));
  pmux_setclr_reg #(.W(NPINS), .RST_VAL(ALL0), .PLAIN(1'b1)) u_shi (
    .clk(clk), .rst_n(rst_q), .we(shi_we), .set(wr_set), .clr(wr_clr), .q(shi_q));

  pmux_pin_mux #(.NPINS(NPINS)) u_mux (
    .own(own_q), .gp_val(out_q), .gp_oe(oe_q), .od(od_q),
    .sel_lo(slo_q), .sel_hi(shi_q),
    .fa_val(fn_a_val), .fa_oe(fn_a_oe), .fb_val(fn_b_val), .fb_oe(fn_b_oe),
    .fc_val(fn_c_val), .fc_oe(fn_c_oe), .fd_val(fn_d_val), .fd_oe(fn_d_oe),
    .drv_val(pad_out), .drv_oe(pad_oe));

  assign pad_pu = pu_q;
  assign pad_pd = pd_q;

  always_comb begin
    case (rd_addr)
      REG_OWN: rd_data = own_q;
      REG_OUT: rd_data = out_q;
      REG_OE:  rd_data = oe_q;
      REG_PU:  rd_data = pu_q;
      REG_PD:  rd_data = pd_q;
      REG_OD:  rd_data = od_q;
      REG_SLO: rd_data = slo_q;
      REG_SHI: rd_data = shi_q;
      REG_PAD: rd_data = pad_q;
      default: rd_data = ALL0;
    endcase
  end

  AST_PULL_EXCL: assert property (@(posedge clk) disable iff (!rst_q)
    ((pad_pu & pad_pd) == '0)) // R6
    else $error("pull-up and pull-down both on");

  AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_q)
    ((od_q & pad_oe & pad_out) == '0)) // R7
    else $error("open-drain pin driving high");

  AST_OWN_STABLE: assert property (@(posedge clk) disable iff (!rst_q)
    !(wr_en && (wr_addr == REG_OWN)) |=> $stable(own_q)) // R2
    else $error("ownership moved without its write");

  AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_q)
    !(wr_en && ((wr_addr == REG_SLO) || (wr_addr == REG_SHI)))
      |=> ($stable(slo_q) && $stable(shi_q))) // R3
    else $error("select moved without its write");
endmodule

// File: tb/sim_pmux_bank.sv
module sim_pmux_bank;
  localparam int CLK_HALF = 5;
  localparam int N = 32;

  logic clk, rst_n, wr_en;
  logic [3:0] wr_addr, rd_addr;
  logic [N-1:0] wr_set, wr_clr, rd_data, pad_in;
  logic [N-1:0] fa_v, fa_o, fb_v, fb_o, fc_v, fc_o, fd_v, fd_o;
  logic [N-1:0] pad_out, pad_oe, pad_pu, pad_pd;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  pmux_bank #(.NPINS(N), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_set(wr_set), .wr_clr(wr_clr), .rd_addr(rd_addr), .rd_data(rd_data),
    .pad_in(pad_in),
    .fn_a_val(fa_v), .fn_a_oe(fa_o), .fn_b_val(fb_v), .fn_b_oe(fb_o),
    .fn_c_val(fc_v), .fn_c_oe(fc_o), .fn_d_val(fd_v), .fn_d_oe(fd_o),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd));

  initial clk = 0;
  always #CLK_HALF clk = ~clk;

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [N-1:0] s, logic [N-1:0] c);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_set = s; wr_clr = c;
    @(negedge clk);
    wr_en = 0; wr_set = '0; wr_clr = '0;
  endtask

  task automatic rd(logic [3:0] a, output logic [N-1:0] v);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic t_reset();
    logic [N-1:0] v;
    rd(0, v); chk("R1 own", v, '1);
    rd(1, v); chk("R1 out", v, '0);
    rd(2, v); chk("R1 oe", v, '0);
    rd(3, v); chk("R1 pu", v, '1);
    rd(4, v); chk("R1 pd", v, '0);
    rd(6, v); chk("R1 sel_lo", v, '0);
    rd(7, v); chk("R1 sel_hi", v, '0);
    chk("R1 pad_oe", pad_oe, '0);
    chk("R1 pad_pu", pad_pu, '1);
  endtask

  task automatic t_gpio_out();
    logic [N-1:0] v;
    wr(1, 32'hF0, 0);
    wr(2, 32'hFF, 0);
    chk("R4 pad_out", pad_out, 32'hF0);
    chk("R4 pad_oe", pad_oe, 32'hFF);
    wr(1, 0, 32'h10);
    rd(1, v); chk("R4 out clear", v, 32'hE0);
    wr(1, 0, 0);
    rd(1, v); chk("R4 zero masks", v, 32'hE0);
    wr(1, 32'h100, 32'h100);
    rd(1, v); chk("R5 clear wins", v, 32'hE0);
  endtask

  task automatic t_mux();
    logic [N-1:0] v;
    wr(0, 0, 32'hF);
    rd(0, v); chk("R2 own", v, 32'hFFFF_FFF0);
    wr(6, 32'hA, 32'hFFFF);
    wr(7, 32'hC, 0);
    rd(6, v); chk("R3 sel_lo plain", v, 32'hA);
    rd(7, v); chk("R3 sel_hi", v, 32'hC);
    fa_v = 32'h1; fb_v = 32'h2; fc_v = 32'h4; fd_v = 32'h8;
    fa_o = 32'h1; fb_o = 32'h2; fc_o = 32'h4; fd_o = 32'h8;
    #1;
    chk("R3 out pat1", pad_out, 32'hEF);
    chk("R3 oe pat1", pad_oe, 32'hFF);
    fa_v = ~32'h1; fb_v = ~32'h2; fc_v = ~32'h4; fd_v = ~32'h8;
    fa_o = ~32'h1; fb_o = ~32'h2; fc_o = ~32'h4; fd_o = ~32'h8;
    #1;
    chk("R3 out pat2", pad_out, 32'hE0);
    chk("R3 oe pat2", pad_oe, 32'hF0);
  endtask

  task automatic t_pull();
    logic [N-1:0] v;
    wr(4, 32'h20, 0);
    rd(3, v); chk("R6 pu cleared", v, 32'hFFFF_FFDF);
    rd(4, v); chk("R6 pd set", v, 32'h20);
    chk("R6 pad_pd", pad_pd, 32'h20);
    wr(3, 32'h20, 0);
    chk("R6 pd cleared", pad_pd, 32'h0);
    chk("R6 pu back", pad_pu, '1);
  endtask

  task automatic t_od();
    fa_v = 32'h1; fb_v = 32'h2; fc_v = 32'h4; fd_v = 32'h8;
    fa_o = 32'h1; fb_o = 32'h2; fc_o = 32'h4; fd_o = 32'h8;
    wr(5, 32'hFF, 0);
    chk("R7 od out", pad_out, 32'h0);
    chk("R7 od oe", pad_oe, 32'h10);
  endtask

  task automatic t_pad();
    logic [N-1:0] v;
    pad_in = 32'h1234_5678;
    @(negedge clk); @(negedge clk);
    rd(8, v); chk("R8 pad level", v, 32'h1234_5678);
    rd(12, v); chk("R8 unmapped", v, 32'h0);
  endtask

  initial begin
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_set = 0; wr_clr = 0;
    rd_addr = 0; pad_in = 0;
    fa_v = 0; fa_o = 0; fb_v = 0; fb_o = 0; fc_v = 0; fc_o = 0; fd_v = 0; fd_o = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_gpio_out();
    t_mux();
    t_pull();
    t_od();
    t_pad();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule